// File: doc/BRIEF.md
# Trace Sample Packer

This block collects trace samples, one per clock, and packs them into 24-bit words for a trace RAM. Each sample has a 3-bit pipeline status, a packet field of up to 16 bits and a sync flag. The packing depends on the configured trace port width. A narrow (4-bit) port puts three samples in 8-bit slots. A medium (8-bit) port puts two samples in 12-bit slots. A wide (16-bit) port puts one sample in a 20-bit slot. When a sample marks a trigger cycle, the packer writes a fixed trigger code into its status field. The real status then moves into the low three bits of the packet field.

Samples arrive on a valid/ready stream, and full words leave on a second valid/ready stream. The word output is a single register. It holds its value for as long as `w_valid` is high and `w_ready` is low. While that register is blocked, the block still accepts samples that leave the word incomplete. It deasserts `s_ready` only for a sample that would complete a word. A level `flush` input pushes out a partially filled word, with the empty slots written as zero. An `empty` flag reports when no sample and no word is pending.

The port width may only change while capture is disabled. A change discards any partial word. Width code 3 stands for a multiplexed port, which is not supported, so no samples are accepted in that setting.

Top module: `tr_sample_packer`

## Requirements
- R1: With `port_mode`=0 (4-bit port), every three accepted samples form one word. The samples fill 8-bit slots at bits 0, 8 and 16 in arrival order. Within a slot, status is at bits 0-2, packet[3:0] at bits 3-6 and sync at bit 7.
- R2: With `port_mode`=1 (8-bit port), every two accepted samples form one word. The slots are 12 bits wide, at bits 0 and 12. Within a slot, status is at bits 0-2, packet[7:0] at bits 3-10 and sync at bit 11. Packet bits above the port width are dropped.
- R3: With `port_mode`=2 (16-bit port), each accepted sample forms one word. Status is at bits 0-2, packet[15:0] at bits 3-18 and sync at bit 19. Bits 23-20 are 0.
- R4: A sample with `s_trig`=1 gets the code TRIG_CODE (default 3'b110) in its status field. Its own status replaces the low three bits of its packet field.
- R5: With `port_mode`=3 (multiplexed port), `s_ready` stays low, so no sample is taken and no word is produced.
- R6: While `cap_en` is low or `flush` is high, `s_ready` is low.
- R7: A word is presented one cycle after its last sample is accepted. `w_valid` and `w_data` hold steady until `w_ready` is high. While the word register is blocked, `s_ready` is low only for a sample that would complete a word.
- R8: While `flush` is high, a partially filled word is emitted with zero in the unfilled slots once the word register is free. Nothing is emitted when no sample is pending.
- R9: A change of `port_mode` discards any partially filled word. The next word then holds only samples taken after the change.
- R10: `empty` is high exactly when no sample is pending and `w_valid` is low.
- R11: After reset, `w_valid` is low and `empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| port_mode | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = multiplexed (rejected) |
| flush | input | 1 | Level request to push out a partial word |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_stat | input | 3 | Sample pipeline status |
| s_packet | input | PKT_W | Sample packet field |
| s_sync | input | 1 | Sample sync flag |
| s_trig | input | 1 | Sample is a trigger cycle |
| w_valid | output | 1 | Packed word valid |
| w_ready | input | 1 | RAM side takes the word |
| w_data | output | WORD_W | Packed word |
| empty | output | 1 | No sample or word pending |

## Verification
The hardest case to reach from the ports has two parts. First, a word must be completing while the previous word is still blocked in the output register. Second, the same blocking must happen when a flush arrives on a partial word. The bench creates both by driving `w_ready` low for random stretches while samples arrive at high density. It then raises `flush` at slot indices that do not line up with a word boundary. A separate sequence disables capture with a partial word in place and changes the width, so the discard path and the restart from slot 0 are both observed.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int STAT_W = 3;

  typedef enum logic [1:0] {
    PW_NARROW = 2'd0,
    PW_MID    = 2'd1,
    PW_WIDE   = 2'd2,
    PW_MUX    = 2'd3
  } port_width_e;

  // samples packed into one RAM word
  function automatic logic [1:0] slots_for(port_width_e m);
    case (m)
      PW_NARROW: return 2'd3;
      PW_MID:    return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  // bits per slot: status + packet + sync
  function automatic logic [4:0] slot_bits_for(port_width_e m);
    case (m)
      PW_NARROW: return 5'd8;
      PW_MID:    return 5'd12;
      default:   return 5'd20;
    endcase
  endfunction
endpackage

// File: rtl/tp_sample_fmt.sv
module tp_sample_fmt
  import tp_pkg::*;
#(
  parameter int          PKT_W     = 16,
  parameter logic [2:0]  TRIG_CODE = 3'b110,
  localparam int         FIELD_W   = PKT_W + STAT_W + 1
) (
  input  port_width_e        mode,
  input  logic [2:0]         stat,
  input  logic [PKT_W-1:0]   pkt,
  input  logic               sync,
  input  logic               trig,
  output logic [FIELD_W-1:0] field
);
  localparam int NVAR = 3;

  // one formatter per supported port width; packet width 4 << g
  for (genvar g = 0; g < NVAR; g++) begin : g_var
    localparam int PW = 4 << g;
    logic [PW-1:0]      p;
    logic [FIELD_W-1:0] f;
    always_comb begin
      p = pkt[PW-1:0];
      if (trig) p[2:0] = stat;
      f = '0;
      f[STAT_W-1:0]    = trig ? TRIG_CODE : stat;
      f[STAT_W +: PW]  = p;
      f[STAT_W + PW]   = sync;
    end
  end

  always_comb begin
    case (mode)
      PW_NARROW: field = g_var[0].f;
      PW_MID:    field = g_var[1].f;
      PW_WIDE:   field = g_var[2].f;
      default:   field = '0;
    endcase
  end
endmodule

// File: rtl/tp_word_acc.sv
module tp_word_acc
  import tp_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int FIELD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_width_e       mode,
  input  logic              clear,
  input  logic              take,
  input  logic [FIELD_W-1:0] field,
  output logic [1:0]        slot,
  output logic              last,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] merged
);
  localparam int POS_W = $clog2(WORD_W) + 1;

  logic [POS_W-1:0] pos;

  always_comb begin
    pos    = POS_W'(slot) * POS_W'(slot_bits_for(mode));
    merged = acc | (WORD_W'(field) << pos);
    last   = (slot == slots_for(mode) - 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      acc  <= '0;
    end else if (clear) begin
      slot <= '0;
      acc  <= '0;
    end else if (take) begin
      if (last) begin
        slot <= '0;
        acc  <= '0;
      end else begin
        slot <= slot + 2'd1;
        acc  <= merged;
      end
    end
  end

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot < slots_for(mode));
endmodule

// File: rtl/tp_out_reg.sv
module tp_out_reg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_word  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !push);
endmodule

// File: rtl/tr_sample_packer.sv
module tr_sample_packer
  import tp_pkg::*;
#(
  parameter int         PKT_W     = 16,
  parameter int         WORD_W    = 24,
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        port_mode,
  input  logic              flush,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [2:0]        s_stat,
  input  logic [PKT_W-1:0]  s_packet,
  input  logic              s_sync,
  input  logic              s_trig,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [WORD_W-1:0] w_data,
  output logic              empty
);
  localparam int FIELD_W = PKT_W + STAT_W + 1;

  port_width_e          mode_q;
  port_width_e          mode_in;
  logic                 mode_chg;
  logic                 mode_ok;
  logic [FIELD_W-1:0]   field;
  logic [1:0]           slot;
  logic                 last;
  logic [WORD_W-1:0]    acc;
  logic [WORD_W-1:0]    merged;
  logic                 free;
  logic                 take;
  logic                 flush_emit;
  logic                 push;
  logic                 clear;
  logic [WORD_W-1:0]    push_word;

  assign mode_in = port_width_e'(port_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PW_NARROW;
    else        mode_q <= mode_in;
  end

  always_comb begin
    mode_chg   = (mode_in != mode_q);
    mode_ok    = (mode_q != PW_MUX);
    s_ready    = cap_en && mode_ok && !flush && !mode_chg && (!last || free);
    take       = s_valid && s_ready;
    flush_emit = flush && !mode_chg && (slot != 2'd0) && free;
    push       = (take && last) || flush_emit;
    push_word  = flush_emit ? acc : merged;
    clear      = mode_chg || flush_emit;
    empty      = (slot == 2'd0) && !w_valid;
  end

  tp_sample_fmt #(.PKT_W(PKT_W), .TRIG_CODE(TRIG_CODE)) fmt_i (
    .mode(mode_q), .stat(s_stat), .pkt(s_packet), .sync(s_sync),
    .trig(s_trig), .field(field)
  );

  tp_word_acc #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .clear(clear), .take(take),
    .field(field), .slot(slot), .last(last), .acc(acc), .merged(merged)
  );

  tp_out_reg #(.WORD_W(WORD_W)) out_i (
    .clk(clk), .rst_n(rst_n), .push(push), .word(push_word),
    .out_ready(w_ready), .out_valid(w_valid), .out_word(w_data), .free(free)
  );

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en || flush) |-> !s_ready);

  assert_reject_mux_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_mode == 2'd3) |-> !s_ready);

  assert_mode_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (slot == 2'd0));

  assert_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !w_valid);
endmodule

// File: tb/tr_sample_packer_tb_top.sv
module tr_sample_packer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  port_mode = 2'd0;
  logic        flush = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [2:0]  s_stat = '0;
  logic [15:0] s_packet = '0;
  logic        s_sync = 1'b0;
  logic        s_trig = 1'b0;
  logic        w_valid;
  logic        w_ready = 1'b0;
  logic [23:0] w_data;
  logic        empty;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [23:0] q[$];
  bit          m_ov = 0;
  logic [23:0] m_ow = '0;
  int          m_mq = 0;
  string       tag = "R1";
  string       word_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tr_sample_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .port_mode(port_mode),
    .flush(flush), .s_valid(s_valid), .s_ready(s_ready), .s_stat(s_stat),
    .s_packet(s_packet), .s_sync(s_sync), .s_trig(s_trig),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .empty(empty)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt(int m, logic [2:0] st, logic [15:0] pk, logic sy, logic tr);
    int w;
    logic [15:0] p;
    logic [2:0]  ps;
    w = 4 << m;
    p = pk & 16'((32'd1 << w) - 1);
    if (tr) p[2:0] = st;
    ps = tr ? 3'b110 : st;
    return 24'(ps) | (24'(p) << 3) | (24'(sy) << (3 + w));
  endfunction

  function automatic logic [23:0] pack_q(int sb);
    logic [23:0] wv = '0;
    foreach (q[i]) wv = wv | (q[i] << (i * sb));
    return wv;
  endfunction

  // one clock: inputs already driven at this negedge
  task automatic step();
    int n;
    int sb;
    bit mchg;
    bit free;
    bit exp_ready;
    #1;
    n  = (m_mq == 0) ? 3 : (m_mq == 1) ? 2 : 1;
    sb = (m_mq == 0) ? 8 : (m_mq == 1) ? 12 : 20;
    mchg = (int'(port_mode) != m_mq);
    free = !m_ov || w_ready;
    exp_ready = cap_en && (m_mq != 3) && !flush && !mchg && (q.size() != n - 1 || free);
    chk(s_ready == exp_ready, tag, "s_ready", longint'(s_ready), longint'(exp_ready));
    if (m_ov && w_ready) m_ov = 0;
    if (mchg) begin
      q.delete();
    end else if (flush && q.size() > 0 && free) begin
      m_ow = pack_q(sb); m_ov = 1; q.delete(); word_tag = "R8";
    end else if (exp_ready && s_valid) begin
      q.push_back(fmt(m_mq, s_stat, s_packet, s_sync, s_trig));
      if (q.size() == n) begin
        m_ow = pack_q(sb); m_ov = 1; q.delete(); word_tag = tag;
      end
    end
    m_mq = int'(port_mode);
    @(negedge clk);
    chk(w_valid == m_ov, word_tag, "w_valid", longint'(w_valid), longint'(m_ov));
    if (m_ov) chk(w_data == m_ow, word_tag, "w_data", longint'(w_data), longint'(m_ow));
    chk(empty == (q.size() == 0 && !m_ov), "R10", "empty", longint'(empty),
        longint'(q.size() == 0 && !m_ov));
  endtask

  task automatic run(int cycles, int vpct, int rpct, int tpct);
    for (int i = 0; i < cycles; i++) begin
      s_valid  = ($urandom_range(99) < vpct);
      w_ready  = ($urandom_range(99) < rpct);
      s_stat   = 3'($urandom_range(7));
      s_packet = 16'($urandom);
      s_sync   = 1'($urandom_range(1));
      s_trig   = ($urandom_range(99) < tpct);
      step();
    end
  endtask

  task automatic drain();
    flush = 1'b1; s_valid = 1'b0; w_ready = 1'b1;
    for (int i = 0; i < 4; i++) step();
    flush = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R11 reset state
    chk(w_valid == 1'b0, "R11", "w_valid in reset", longint'(w_valid), 0);
    chk(empty == 1'b1, "R11", "empty in reset", longint'(empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(empty == 1'b1, "R11", "empty after reset", longint'(empty), 1);

    // R1 narrow port, free-flowing output
    cap_en = 1'b1; tag = "R1";
    run(60, 80, 100, 0);
    // R7 back-pressure with dense input
    tag = "R7";
    run(120, 90, 30, 10);
    drain();

    // R4 directed trigger sample on the wide port
    cap_en = 1'b0; port_mode = 2'd2; step();
    cap_en = 1'b1; tag = "R4"; w_ready = 1'b1;
    s_valid = 1'b1; s_stat = 3'b101; s_packet = 16'hABC8; s_sync = 1'b1; s_trig = 1'b1;
    step();
    s_valid = 1'b0; s_trig = 1'b0;
    chk(w_data == 24'h0D5E6E, "R4", "trigger word", longint'(w_data), 24'h0D5E6E);
    step();

    // R6 capture disabled with valid samples offered
    cap_en = 1'b0; tag = "R6";
    run(10, 100, 100, 0);

    // R2 medium port, random back-pressure and triggers
    port_mode = 2'd1; step();
    cap_en = 1'b1; tag = "R2";
    run(120, 85, 60, 10);
    // R8 flush with one sample pending and output blocked
    tag = "R8";
    s_valid = 1'b1; w_ready = 1'b1; step();
    while (q.size() != 1) step();
    s_valid = 1'b0; w_ready = 1'b0; flush = 1'b1;
    step(); step();
    w_ready = 1'b1; step(); step();
    flush = 1'b0; step();

    // R9 width change with a partial word pending
    port_mode = 2'd0; step();
    tag = "R9"; s_valid = 1'b1;
    step();
    s_valid = 1'b0; step();
    cap_en = 1'b0; port_mode = 2'd2; step();
    chk(empty == 1'b1, "R9", "partial discarded", longint'(empty), 1);
    cap_en = 1'b1;
    run(8, 100, 100, 0);

    // R3 wide port under random traffic
    tag = "R3";
    run(80, 70, 50, 15);
    drain();

    // R5 multiplexed setting rejected
    cap_en = 1'b0; port_mode = 2'd3; step();
    cap_en = 1'b1; tag = "R5";
    run(20, 100, 100, 0);
    chk(w_valid == 1'b0, "R5", "no word produced", longint'(w_valid), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule